// File: doc/BRIEF.md
# Shared Address/Data Bus Pad Controller

This block controls an eight-pin bidirectional port. The pins are shared between a multiplexed external address/data bus and general-purpose I/O. While the bus controller runs a cycle, it owns every pin. In the address and write-data phases it drives the pins push-pull. In the read phases it releases them, and it captures read data on a strobe phase.

Between bus cycles the pins follow three software registers:

- an output-value register;
- a direction register;
- a port-wide control bit that chooses complementary or open-drain drive.

A strap input can tie the port to bus-only duty. With the strap set, the pins never act as I/O and register writes are ignored. All pad outputs are registered, so every pin change appears one clock after the cause. Pin levels pass through a synchronizer before software reads them.

Top module: `shared_ad_port`

## Requirements
- R1: A synchronous reset releases every pin (pad_oe_o = 0, pad_out_o = 0) on the following edge. Reset also sets the output-value register to all ones, the direction register to zero and the control register to zero, which selects complementary drive.
- R2: Phase codes when bus_req_i is high: 0 = address, 1 = write data, 2 = read, 3 = read strobe. In the address or write-data phase, the next edge sets pad_oe_o to all ones and pad_out_o to bus_out_i, whatever the registers hold.
- R3: In the read phase (2) or the read-strobe phase (3), the next edge sets pad_oe_o and pad_out_o to zero.
- R4: bus_rdata_o loads pad_in_i on every edge where bus_req_i is high and the phase is 3. At all other edges it holds its value.
- R5: With bus_req_i and bus_only_i both low and the control bit at 0, each pin whose direction bit is 1 is driven with its output-value bit. Each pin whose direction bit is 0 is released. Both take effect on the next edge.
- R6: With control bit 0 set to 1, every output pin uses open-drain drive. An output-value bit of 1 releases its pin. An output-value bit of 0 drives it low. The setting covers all pins together.
- R7: Once bus_req_i falls, the pins return to the register-defined state on the next edge. A bus cycle never alters the register contents.
- R8: While bus_only_i is high, register writes leave the registers unchanged. Pins follow the bus during a request and are released otherwise.
- R9: Reading register address 3 returns pad_in_i after SYNC_STAGES clock edges.
- R10: The register map is: address 0 holds the output value, address 1 the direction (1 = output), address 2 holds the open-drain bit at bit 0, and address 3 holds the synchronized pins. A write takes effect at the next edge, and reg_rdata_o shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_only_i | input | 1 | Strap: port serves only as address/data bus |
| bus_req_i | input | 1 | External bus cycle active |
| bus_phase_i | input | 2 | Bus phase code (see R2) |
| bus_out_i | input | WIDTH | Address or write data from the bus controller |
| bus_rdata_o | output | WIDTH | Read data captured on the strobe phase |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | WIDTH | Register write data |
| reg_rdata_o | output | WIDTH | Register read data |
| pad_in_i | input | WIDTH | Pin levels from the input buffers |
| pad_out_o | output | WIDTH | Per-pin output value |
| pad_oe_o | output | WIDTH | Per-pin output enable |

## Verification
The bench builds the block with its default parameters: WIDTH = 8 and SYNC_STAGES = 2. Eight pins allow direction and value patterns such as 0xF0 and 0xA5, which put driven, released, high and low pins side by side in one vector. Two synchronizer stages make it possible to observe that a readback is still stale after one edge and becomes current after the second.

// File: rtl/port_pkg.sv
package port_pkg;
  typedef enum logic [1:0] {
    PH_ADDR    = 2'd0,
    PH_WDATA   = 2'd1,
    PH_READ    = 2'd2,
    PH_RSTROBE = 2'd3
  } bus_phase_e;

  localparam logic [1:0] RA_VALUE = 2'd0;
  localparam logic [1:0] RA_DIR   = 2'd1;
  localparam logic [1:0] RA_CTRL  = 2'd2;
  localparam logic [1:0] RA_PINS  = 2'd3;
endpackage

// File: rtl/port_sync.sv
module port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs
  import port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pins_sync,
  output logic [WIDTH-1:0] value_q,
  output logic [WIDTH-1:0] dir_q,
  output logic             od_q,
  output logic [WIDTH-1:0] rdata
);
  logic wr_ok;
  assign wr_ok = wr_en && !lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '1;
      dir_q   <= '0;
      od_q    <= 1'b0;
    end else if (wr_ok) begin
      case (addr)
        RA_VALUE: value_q <= wdata;
        RA_DIR:   dir_q   <= wdata;
        RA_CTRL:  od_q    <= wdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      RA_VALUE: rdata = value_q;
      RA_DIR:   rdata = dir_q;
      RA_CTRL:  rdata = {{(WIDTH-1){1'b0}}, od_q};
      default:  rdata = pins_sync;
    endcase
  end

  // R8: strap blocks every register update
  assert_strap_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (lock && wr_en) |=> ($stable(value_q) && $stable(dir_q) && $stable(od_q)));
endmodule

// File: rtl/port_pad_mux.sv
module port_pad_mux
  import port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_req,
  input  logic             lock,
  input  bus_phase_e       phase,
  input  logic [WIDTH-1:0] bus_out,
  input  logic [WIDTH-1:0] value,
  input  logic [WIDTH-1:0] dir,
  input  logic             od,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  logic bus_drive;
  assign bus_drive = (phase == PH_ADDR) || (phase == PH_WDATA);

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic nxt_out, nxt_oe;
    always_comb begin
      nxt_out = 1'b0;
      nxt_oe  = 1'b0;
      if (bus_req) begin
        if (bus_drive) begin
          nxt_out = bus_out[p];
          nxt_oe  = 1'b1;
        end
      end else if (!lock && dir[p]) begin
        if (od) begin
          nxt_oe = !value[p];
        end else begin
          nxt_out = value[p];
          nxt_oe  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[p] <= 1'b0;
        pad_oe[p]  <= 1'b0;
      end else begin
        pad_out[p] <= nxt_out;
        pad_oe[p]  <= nxt_oe;
      end
    end
  end

  // R2: bus drive phases own all pins push-pull
  assert_bus_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_drive) |=> (pad_oe == '1 && pad_out == $past(bus_out)));
  // R3: read phases release the pins
  assert_read_release_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_drive) |=> (pad_oe == '0));
  // R6: open-drain never drives a high level
  assert_od_no_high_R6: assert property (@(posedge clk) disable iff (rst)
    (!bus_req && !lock && od) |=> ((pad_out & pad_oe) == '0));
  // R8: strap idle leaves pins released
  assert_strap_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (lock && !bus_req) |=> (pad_oe == '0));
endmodule

// File: rtl/shared_ad_port.sv
module shared_ad_port
  import port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_only_i,
  input  logic             bus_req_i,
  input  logic [1:0]       bus_phase_i,
  input  logic [WIDTH-1:0] bus_out_i,
  output logic [WIDTH-1:0] bus_rdata_o,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  output logic [WIDTH-1:0] reg_rdata_o,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  bus_phase_e       phase;
  logic [WIDTH-1:0] pins_sync, value_q, dir_q;
  logic             od_q;
  logic             strobe;

  assign phase  = bus_phase_e'(bus_phase_i);
  assign strobe = bus_req_i && (phase == PH_RSTROBE);

  port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in_i), .dout(pins_sync)
  );

  port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .lock(bus_only_i), .wr_en(reg_wr_i),
    .addr(reg_addr_i), .wdata(reg_wdata_i), .pins_sync(pins_sync),
    .value_q(value_q), .dir_q(dir_q), .od_q(od_q), .rdata(reg_rdata_o)
  );

  port_pad_mux #(.WIDTH(WIDTH)) u_mux (
    .clk(clk), .rst(rst), .bus_req(bus_req_i), .lock(bus_only_i),
    .phase(phase), .bus_out(bus_out_i), .value(value_q), .dir(dir_q),
    .od(od_q), .pad_out(pad_out_o), .pad_oe(pad_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata_o <= '0;
    else if (strobe) bus_rdata_o <= pad_in_i;
  end

  // R4: capture on strobe, hold otherwise
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (bus_rdata_o == $past(pad_in_i)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(bus_rdata_o));
  // R7: bus cycles leave the registers untouched
  assert_bus_keeps_regs_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req_i && !reg_wr_i) |=> ($stable(value_q) && $stable(dir_q) && $stable(od_q)));
endmodule

// File: tb/tb_shared_ad_port.sv
module tb_shared_ad_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_only = 1'b0, bus_req = 1'b0, reg_wr = 1'b0;
  logic [1:0]   phase = 2'd0, reg_addr = 2'd0;
  logic [W-1:0] bus_out = '0, reg_wdata = '0, pad_in = '0;
  logic [W-1:0] bus_rdata, reg_rdata, pad_out, pad_oe;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  shared_ad_port #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .bus_only_i(bus_only), .bus_req_i(bus_req),
    .bus_phase_i(phase), .bus_out_i(bus_out), .bus_rdata_o(bus_rdata),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe)
  );

  // {bus_only, req, phase[1:0], bus_out, exp_oe, exp_out}; regs value=A5 dir=F0 ctrl=0
  localparam logic [27:0] VEC [9] = '{
    {1'b0, 1'b0, 2'd0, 8'h00, 8'hF0, 8'hA0},  // R5 idle complementary
    {1'b0, 1'b1, 2'd0, 8'h3C, 8'hFF, 8'h3C},  // R2 address
    {1'b0, 1'b1, 2'd1, 8'hC3, 8'hFF, 8'hC3},  // R2 write data
    {1'b0, 1'b1, 2'd2, 8'hFF, 8'h00, 8'h00},  // R3 read
    {1'b0, 1'b1, 2'd3, 8'hFF, 8'h00, 8'h00},  // R3 strobe
    {1'b0, 1'b0, 2'd0, 8'h00, 8'hF0, 8'hA0},  // R7 return to I/O
    {1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00},  // R8 strap idle
    {1'b1, 1'b1, 2'd0, 8'h5A, 8'hFF, 8'h5A},  // R8 strap bus
    {1'b0, 1'b0, 2'd1, 8'h00, 8'hF0, 8'hA0}   // R7 back to I/O
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 oe", pad_oe, 8'h00);
    check("R1 out", pad_out, 8'h00);
    reg_addr = 2'd0; #1 check("R1 value", reg_rdata, 8'hFF);
    reg_addr = 2'd1; #1 check("R1 dir", reg_rdata, 8'h00);
    reg_addr = 2'd2; #1 check("R1 ctrl", reg_rdata, 8'h00);

    // R10 configuration and readback
    reg_write(2'd0, 8'hA5);
    reg_write(2'd1, 8'hF0);
    reg_write(2'd2, 8'h00);
    reg_addr = 2'd0; #1 check("R10 value", reg_rdata, 8'hA5);
    reg_addr = 2'd1; #1 check("R10 dir", reg_rdata, 8'hF0);
    tick();

    for (int i = 0; i < 9; i++) begin
      bus_only = VEC[i][27];
      bus_req  = VEC[i][26];
      phase    = VEC[i][25:24];
      bus_out  = VEC[i][23:16];
      tick();
      check($sformatf("vec%0d oe R2/R3/R5/R7/R8", i), pad_oe, VEC[i][15:8]);
      check($sformatf("vec%0d out R2/R3/R5/R7/R8", i), pad_out, VEC[i][7:0]);
    end

    // R7 registers survive bus cycles
    reg_addr = 2'd0; #1 check("R7 value kept", reg_rdata, 8'hA5);
    reg_addr = 2'd1; #1 check("R7 dir kept", reg_rdata, 8'hF0);

    // R6 open-drain: value A5, dir F0 -> pins 6 and 4 pulled low
    reg_write(2'd2, 8'h01);
    tick();
    check("R6 oe", pad_oe, 8'h50);
    check("R6 out", pad_out, 8'h00);
    reg_write(2'd2, 8'h00);
    tick();
    check("R6 back to push-pull", pad_oe, 8'hF0);

    // R4 capture on strobe, then hold
    pad_in = 8'h96; bus_req = 1'b1; phase = 2'd3;
    tick();
    check("R4 capture", bus_rdata, 8'h96);
    pad_in = 8'h11; phase = 2'd2;
    tick();
    check("R4 hold in read", bus_rdata, 8'h96);
    bus_req = 1'b0; phase = 2'd3;
    tick();
    check("R4 hold idle", bus_rdata, 8'h96);

    // R8 writes ignored under strap
    bus_only = 1'b1;
    reg_write(2'd0, 8'h00);
    reg_write(2'd1, 8'h0F);
    reg_addr = 2'd0; #1 check("R8 value locked", reg_rdata, 8'hA5);
    reg_addr = 2'd1; #1 check("R8 dir locked", reg_rdata, 8'hF0);
    check("R8 pins released", pad_oe, 8'h00);
    bus_only = 1'b0;

    // R9 pin readback through synchronizer
    reg_addr = 2'd3;
    tick();
    pad_in = 8'h3E;
    tick();
    check("R9 stale after one edge", reg_rdata, 8'h11);
    tick();
    check("R9 current after two edges", reg_rdata, 8'h3E);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule